// File: doc/BRIEF.md
# Start-Stop Serial Register Writer

This block receives register writes over a single data line sampled on a bit clock. The line rests high. A frame starts with one low start bit and carries 15 payload bits, most significant first. A high stop bit closes it. The payload holds a 4-bit cascade address, a 3-bit register index and an 8-bit value. A frame that is accepted writes the value into a small on-chip register bank. There is no read path.

Several copies of the block share one line, and each copy has a different cascade address set by a parameter. Two reserved payload words switch a broadcast state on and off. While broadcast is on, a copy ignores the cascade address field, so one frame writes the same register in every copy. The receiver only runs while a 2-bit interface-select input holds the value 01.

Top module: `serial_reg_writer`

## Requirements
- R1: While the line is idle it is high. A 0 sampled on a rising clock edge while idle starts a frame. The next 15 samples are payload bits, MSB first, and the sample after them is the stop bit.
- R2: Payload bits 14..11 are the cascade address, bits 10..8 the register index and bits 7..0 the value. A frame whose cascade address equals parameter DEV_ADDR writes the value into register index N, which is output on reg_bank[8N+7:8N].
- R3: When broadcast is off, a frame whose cascade address differs from DEV_ADDR changes no register.
- R4: Payload 0x78FF (binary 111_1000_1111_1111) turns broadcast on. Payload 0x7800 (binary 111_1000_0000_0000) turns it off. The state is shown on bcast_on (1 = on). Both words act whatever DEV_ADDR is.
- R5: While broadcast is on, a frame with any cascade address writes its register.
- R6: Register index 0 is never written and reads as 0x00. A payload with index 0 that is not one of the two broadcast words has no effect.
- R7: If the stop bit samples 0, the frame is discarded. The receiver is idle again at the next sample.
- R8: When the stop bit samples 1 at clock edge E, the register or broadcast update appears on the outputs after edge E+1 and not after edge E.
- R9: While mode_sel is not 01, the receiver stays idle and low samples are ignored. Any partly received frame is abandoned.
- R10: Synchronous active-high reset clears all registers and turns broadcast off.
- R11: A start bit sampled at edge E+1, the edge that commits the previous frame, begins a new frame that is received correctly.

Port order follows the module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; the line is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Interface select; the receiver runs only at 01 |
| sdata | input | 1 | Serial data line |
| reg_bank | output | 64 | All eight registers; register N is on bits 8N+7..8N |
| bcast_on | output | 1 | Broadcast state (1 = on) |

## Verification
Two things can happen on the same clock edge. One is the commit of a finished frame. The other is the sampling of the next frame's start bit, which happens when a second frame follows its predecessor's stop bit with no idle gap. The bench sends two frames back to back, so the start bit of the second lands on the first frame's commit edge. It then checks that both registers hold their own values, which shows that the commit did not disturb the new frame's bit count. A separate directed test samples reg_bank between the stop-bit edge and the commit edge to pin down the one-cycle delay.

// File: rtl/ssw_pkg.sv
package ssw_pkg;

    localparam int DEV_W   = 4;
    localparam int IDX_W   = 3;
    localparam int VAL_W   = 8;
    localparam int FRAME_W = DEV_W + IDX_W + VAL_W;
    localparam int NREGS   = 1 << IDX_W;
    localparam int CNT_W   = $clog2(FRAME_W);

    localparam logic [1:0] SEL_ACTIVE = 2'b01;

    typedef struct packed {
        logic [DEV_W-1:0] dev;
        logic [IDX_W-1:0] idx;
        logic [VAL_W-1:0] val;
    } frame_t;

    localparam frame_t WORD_BC_ON  = '{dev: '1, idx: '0, val: '1};
    localparam frame_t WORD_BC_OFF = '{dev: '1, idx: '0, val: '0};

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_BITS = 2'd1,
        RX_STOP = 2'd2
    } rx_state_t;

    function automatic logic is_ctrl_word(frame_t f);
        return (f == WORD_BC_ON) || (f == WORD_BC_OFF);
    endfunction

endpackage

// File: rtl/ssw_deframer.sv
module ssw_deframer
    import ssw_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   active_i,
    input  logic   sdata_i,
    output logic   frame_vld_o,
    output frame_t frame_o
);

    rx_state_t          state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] shift_q;
    logic               vld_q;
    frame_t             word_q;

    always_ff @(posedge clk) begin
        if (rst || !active_i) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
            vld_q   <= 1'b0;
            word_q  <= '0;
        end else begin
            vld_q <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    if (!sdata_i) begin
                        state_q <= RX_BITS;
                        cnt_q   <= '0;
                    end
                end
                RX_BITS: begin
                    shift_q <= {shift_q[FRAME_W-2:0], sdata_i};
                    if (cnt_q == CNT_W'(FRAME_W - 1)) begin
                        state_q <= RX_STOP;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (sdata_i) begin
                        vld_q  <= 1'b1;
                        word_q <= frame_t'(shift_q);
                    end
                    state_q <= RX_IDLE;
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    assign frame_vld_o = vld_q;
    assign frame_o     = word_q;

    // R7: a frame is only released after a stop bit that sampled high
    assert_stop_high_R7: assert property (@(posedge clk) disable iff (rst)
        frame_vld_o |-> ($past(sdata_i) && $past(state_q) == RX_STOP));

    // R9: an inactive interface never releases a frame on the next edge
    assert_inactive_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> !frame_vld_o);

endmodule

// File: rtl/ssw_commit.sv
module ssw_commit
    import ssw_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ADDR = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_vld_i,
    input  frame_t           frame_i,
    output logic             bcast_o,
    output logic             we_o,
    output logic [IDX_W-1:0] waddr_o,
    output logic [VAL_W-1:0] wdata_o
);

    logic bcast_q;
    logic addr_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            bcast_q <= 1'b0;
        end else if (frame_vld_i) begin
            if (frame_i == WORD_BC_ON) begin
                bcast_q <= 1'b1;
            end else if (frame_i == WORD_BC_OFF) begin
                bcast_q <= 1'b0;
            end
        end
    end

    always_comb begin
        addr_hit = bcast_q || (frame_i.dev == DEV_ADDR);
        we_o     = frame_vld_i && addr_hit && (frame_i.idx != '0)
                   && !is_ctrl_word(frame_i);
        waddr_o  = frame_i.idx;
        wdata_o  = frame_i.val;
    end

    assign bcast_o = bcast_q;

    // R4: broadcast state moves only on the edge after a released frame
    assert_bcast_moves_on_frame_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(bcast_q) |-> $past(frame_vld_i));

endmodule

// File: rtl/ssw_regbank.sv
module ssw_regbank
    import ssw_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we_i,
    input  logic [IDX_W-1:0]       waddr_i,
    input  logic [VAL_W-1:0]       wdata_i,
    output logic [NREGS*VAL_W-1:0] bank_o
);

    assign bank_o[VAL_W-1:0] = '0;

    for (genvar g = 1; g < NREGS; g++) begin : g_reg
        logic [VAL_W-1:0] val_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                val_q <= '0;
            end else if (we_i && waddr_i == IDX_W'(g)) begin
                val_q <= wdata_i;
            end
        end
        assign bank_o[g*VAL_W +: VAL_W] = val_q;
    end

    // R6: the commit stage never targets the reserved index
    assert_no_index0_write_R6: assert property (@(posedge clk) disable iff (rst)
        we_i |-> (waddr_i != '0));

endmodule

// File: rtl/serial_reg_writer.sv
module serial_reg_writer
    import ssw_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ADDR = 4'd3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             mode_sel,
    input  logic                   sdata,
    output logic [NREGS*VAL_W-1:0] reg_bank,
    output logic                   bcast_on
);

    logic             active;
    logic             frame_vld;
    frame_t           frame;
    logic             we;
    logic [IDX_W-1:0] waddr;
    logic [VAL_W-1:0] wdata;

    assign active = (mode_sel == SEL_ACTIVE);

    ssw_deframer u_deframer (
        .clk         (clk),
        .rst         (rst),
        .active_i    (active),
        .sdata_i     (sdata),
        .frame_vld_o (frame_vld),
        .frame_o     (frame)
    );

    ssw_commit #(.DEV_ADDR(DEV_ADDR)) u_commit (
        .clk         (clk),
        .rst         (rst),
        .frame_vld_i (frame_vld),
        .frame_i     (frame),
        .bcast_o     (bcast_on),
        .we_o        (we),
        .waddr_o     (waddr),
        .wdata_o     (wdata)
    );

    ssw_regbank u_regbank (
        .clk     (clk),
        .rst     (rst),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wdata),
        .bank_o  (reg_bank)
    );

endmodule

// File: tb/test_serial_reg_writer.sv
module test_serial_reg_writer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_sel = 2'b01;
    logic        sdata = 1'b1;
    logic [63:0] reg_bank;
    logic        bcast_on;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] m_reg [8];
    logic       m_bc;

    always #2 clk = ~clk;

    serial_reg_writer #(.DEV_ADDR(4'd3)) i_serial_reg_writer (
        .clk      (clk),
        .rst      (rst),
        .mode_sel (mode_sel),
        .sdata    (sdata),
        .reg_bank (reg_bank),
        .bcast_on (bcast_on)
    );

    // entry: {requirement number, payload[14:0], stop bit}
    localparam logic [19:0] VEC [12] = '{
        {4'd2, 4'd3, 3'd5, 8'hA5, 1'b1},  // R2 R1 own address, reg 5
        {4'd2, 4'd3, 3'd1, 8'h3C, 1'b1},  // R2 reg 1
        {4'd3, 4'd7, 3'd2, 8'h11, 1'b1},  // R3 foreign address ignored
        {4'd6, 4'd3, 3'd0, 8'h55, 1'b1},  // R6 index 0 ignored
        {4'd7, 4'd3, 3'd4, 8'h99, 1'b0},  // R7 bad stop bit
        {4'd4, 15'h78FF,          1'b1},  // R4 broadcast on
        {4'd5, 4'd9, 3'd2, 8'h22, 1'b1},  // R5 any address
        {4'd5, 4'd0, 3'd6, 8'h6E, 1'b1},  // R5
        {4'd4, 15'h7800,          1'b1},  // R4 broadcast off
        {4'd3, 4'd9, 3'd7, 8'h77, 1'b1},  // R3 ignored again
        {4'd2, 4'd3, 3'd7, 8'hF0, 1'b1},  // R2
        {4'd2, 4'd3, 3'd5, 8'h00, 1'b1}   // R2 overwrite
    };

    function automatic logic [63:0] model_bank();
        logic [63:0] b;
        for (int i = 0; i < 8; i++) b[i*8 +: 8] = m_reg[i];
        return b;
    endfunction

    task automatic model_frame(logic [14:0] w, logic stop);
        if (stop) begin
            if (w == 15'h78FF) m_bc = 1'b1;
            else if (w == 15'h7800) m_bc = 1'b0;
            else if (w[10:8] != 3'd0 && (m_bc || w[14:11] == 4'd3))
                m_reg[w[10:8]] = w[7:0];
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
        m_bc = 1'b0;
    endtask

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drives start, 15 payload bits and the stop bit, one per negedge
    task automatic send(logic [14:0] w, logic stop);
        @(negedge clk) sdata = 1'b0;
        for (int b = 14; b >= 0; b--) begin
            @(negedge clk) sdata = w[b];
        end
        @(negedge clk) sdata = stop;
    endtask

    task automatic settle();
        @(negedge clk) sdata = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        sdata = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
        model_clear();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk("R10 reset regs", reg_bank, 64'h0);
        chk("R10 reset bcast", {63'h0, bcast_on}, 64'h0);

        // table walk
        for (int v = 0; v < 12; v++) begin
            send(VEC[v][15:1], VEC[v][0]);
            settle();
            model_frame(VEC[v][15:1], VEC[v][0]);
            chk($sformatf("R%0d vec %0d regs", VEC[v][19:16], v), reg_bank, model_bank());
            chk($sformatf("R%0d vec %0d bcast", VEC[v][19:16], v),
                {63'h0, bcast_on}, {63'h0, m_bc});
        end

        // R8: not visible after the stop-bit edge, visible one edge later
        send({4'd3, 3'd4, 8'hC3}, 1'b1);
        @(negedge clk) sdata = 1'b1;
        chk("R8 before commit", reg_bank, model_bank());
        model_frame({4'd3, 3'd4, 8'hC3}, 1'b1);
        @(negedge clk);
        chk("R8 after commit", reg_bank, model_bank());

        // R11: next start bit sampled on the commit edge
        send({4'd3, 3'd1, 8'h5A}, 1'b1);
        send({4'd3, 3'd2, 8'hB6}, 1'b1);
        settle();
        model_frame({4'd3, 3'd1, 8'h5A}, 1'b1);
        model_frame({4'd3, 3'd2, 8'hB6}, 1'b1);
        chk("R11 back-to-back", reg_bank, model_bank());

        // R9: inactive select ignores a whole frame
        @(negedge clk) mode_sel = 2'b00;
        send({4'd3, 3'd3, 8'hEE}, 1'b1);
        settle();
        chk("R9 inactive frame ignored", reg_bank, model_bank());

        // R9: partial frame abandoned when select drops
        @(negedge clk) mode_sel = 2'b01;
        @(negedge clk) sdata = 1'b0;
        for (int b = 0; b < 5; b++) begin
            @(negedge clk) sdata = b[0];
        end
        @(negedge clk) begin mode_sel = 2'b10; sdata = 1'b1; end
        @(negedge clk) mode_sel = 2'b01;
        send({4'd3, 3'd6, 8'h81}, 1'b1);
        settle();
        model_frame({4'd3, 3'd6, 8'h81}, 1'b1);
        chk("R9 partial abandoned", reg_bank, model_bank());

        // R7: after a bad stop the very next start bit is accepted
        send({4'd3, 3'd3, 8'h44}, 1'b0);
        send({4'd3, 3'd3, 8'h45}, 1'b1);
        settle();
        model_frame({4'd3, 3'd3, 8'h45}, 1'b1);
        chk("R7 resync after bad stop", reg_bank, model_bank());

        // R6: index 0 stays zero even in broadcast
        send(15'h78FF, 1'b1);
        send({4'd5, 3'd0, 8'h12}, 1'b1);
        settle();
        model_frame(15'h78FF, 1'b1);
        chk("R6 index 0 in broadcast", reg_bank, model_bank());
        chk("R4 bcast on again", {63'h0, bcast_on}, 64'h1);

        // R10: reset clears broadcast and registers
        do_reset();
        @(negedge clk);
        chk("R10 clear regs", reg_bank, 64'h0);
        chk("R10 clear bcast", {63'h0, bcast_on}, 64'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule